// File: doc/BRIEF.md
# Sigma-Delta Fractional-N Feedback Divider

This block divides a high-rate input clock by a ratio that changes from one division cycle to the next. A second-order noise-shaping modulator sets each cycle's ratio. Over many cycles the mean ratio equals an integer part N plus a binary fraction. The fraction is 23 bits wide. Software sets its upper 22 bits, and the lowest bit is tied to one inside the block. Tying that bit high keeps the modulator out of short repeating patterns. Each output sequence then runs the longest possible length before it repeats.

The modulator is two cascaded accumulators. The first carry, plus the current second carry, minus the second carry of the previous step, gives an offset between -1 and +2. This offset is added to N. The sum reloads a down-counter, which emits one pulse per division cycle. The cycle that follows the pulse is the one the phase comparator measures. The modulator advances once on each pulse, so the ratio for a cycle is settled before that cycle begins.

N and the fraction are sampled only at a cycle boundary. Changes that arrive between boundaries wait for the next one.

Top module: `sdm_frac_divider`

## Requirements
- R1: While the synchronous reset is high, both accumulators and the stored previous second carry are cleared. `ratio_now` reads 0, `mod_offset` reads 1 and `div_pulse` is high. The first clock after reset release is a cycle boundary, and the cycle it opens has ratio N.
- R2: Every momentary ratio lies in N-1..N+2, where N is the value sampled at the boundary that opened the cycle.
- R3: `mod_offset` carries the offset with a bias of one: code 0 means -1, 1 means 0, 2 means +1 and 3 means +2. `ratio_now` equals the sampled N plus the code minus one.
- R4: `div_pulse` is high for exactly one clock per division cycle. The number of clocks from one pulse to the next equals the `ratio_now` shown during that cycle.
- R5: The effective fraction is K = {k_frac, 1}. With k_frac = 0 and N = 5, cycles 1..4095 after reset have ratio 5, cycle 4096 has ratio 6 and cycle 4097 has ratio 4.
- R6: Over the first M cycles after reset, the total clock count is M·N + floor(M·K / 2^23), plus 0 or 1.
- R7: A change on `n_ratio` or `k_frac` that arrives while `div_pulse` is low has no effect on the current cycle. It takes effect at the next boundary.
- R8: A synchronous reset in the middle of a run restarts the ratio sequence. The restarted sequence is identical to the sequence that followed the earlier reset.
- R9: Each cycle's offset equals c1 + c2 - c2prev. Here c1 is the carry out of the first accumulator when K is added. c2 is the carry out of the second accumulator when the first accumulator's new value is added to it. c2prev is the previous c2.
- R10: `ratio_now` and `mod_offset` hold steady for the whole division cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock standing in for the oscillator |
| rst | input | 1 | Synchronous reset, active high |
| n_ratio | input | N_W | Integer ratio N, must be 3 or more |
| k_frac | input | FRAC_W-1 | Programmable upper fraction bits |
| div_pulse | output | 1 | One-clock pulse marking each cycle boundary |
| ratio_now | output | N_W+1 | Ratio of the division cycle in progress |
| mod_offset | output | 2 | Biased modulator offset of the cycle in progress |

## Verification
The bench builds the block with its defaults: a 10-bit N and a 23-bit fraction. These values put both the smallest legal ratio (3) and a ratio near the top of the range (1000) within reach. They also let a run with the smallest fraction, one LSB, last long enough for the second accumulator to overflow, which first happens at cycle 4096 after reset. That overflow produces the +1 followed by -1 step that only a forced low bit can cause. An all-ones fraction exercises the +2 offset.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Biased offset code: value = code - 1
  typedef enum logic [1:0] {
    OFS_M1 = 2'd0,
    OFS_Z  = 2'd1,
    OFS_P1 = 2'd2,
    OFS_P2 = 2'd3
  } ofs_code_e;

  // Second-order combine: c1 + c2 - c2_prev, biased by one
  function automatic ofs_code_e ofs_encode(input logic c1, input logic c2, input logic c2_prev);
    logic [1:0] t;
    t = 2'd1 + {1'b0, c1} + {1'b0, c2} - {1'b0, c2_prev};
    return ofs_code_e'(t);
  endfunction

  // Number of cascaded accumulator stages
  localparam int unsigned SDM_ORDER = 2;

endpackage

// File: rtl/sdm_acc_stage.sv
module sdm_acc_stage #(
  parameter int unsigned W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_next,
  output logic         carry_next,
  output logic [W-1:0] acc_q
);

  logic [W:0] sum_full;

  always_comb begin
    sum_full   = {1'b0, acc_q} + {1'b0, addend};
    sum_next   = sum_full[W-1:0];
    carry_next = sum_full[W];
  end

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= sum_next;
  end

  // R7: the accumulator moves only on a boundary
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q));

endmodule

// File: rtl/sdm_mash11.sv
module sdm_mash11
  import sdm_pkg::*;
#(
  parameter int unsigned FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [FRAC_W-2:0] k_prog,
  output ofs_code_e         ofs_next,
  output logic              c1_evt,
  output logic              c2_evt
);

  localparam int unsigned NST = SDM_ORDER;

  logic [FRAC_W-1:0] k_full;
  logic [FRAC_W-1:0] stage_in  [NST+1];
  logic [FRAC_W-1:0] stage_acc [NST];
  logic [NST-1:0]    carry;
  logic              c2_prev_q;

  // Lowest fraction bit tied high (R5)
  assign k_full      = {k_prog, 1'b1};
  assign stage_in[0] = k_full;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    sdm_acc_stage #(.W(FRAC_W)) stage_i (
      .clk       (clk),
      .rst       (rst),
      .step      (step),
      .addend    (stage_in[g]),
      .sum_next  (stage_in[g+1]),
      .carry_next(carry[g]),
      .acc_q     (stage_acc[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)       c2_prev_q <= 1'b0;
    else if (step) c2_prev_q <= carry[1];
  end

  assign c1_evt   = carry[0];
  assign c2_evt   = carry[1];
  assign ofs_next = ofs_encode(c1_evt, c2_evt, c2_prev_q);

  // R9: a -1 offset is only reachable after a second-stage carry
  p_neg_needs_prev_r9: assert property (@(posedge clk) disable iff (rst)
    (ofs_next == OFS_M1) |-> c2_prev_q);

  // R9: +2 requires both carries in this step
  p_p2_needs_both_r9: assert property (@(posedge clk) disable iff (rst)
    (ofs_next == OFS_P2) |-> (c1_evt && c2_evt));

endmodule

// File: rtl/sdm_ratio_sum.sv
module sdm_ratio_sum
  import sdm_pkg::*;
#(
  parameter int unsigned N_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [N_W-1:0] n_in,
  input  ofs_code_e      ofs_in,
  output logic [N_W:0]   ratio_next,
  output logic [N_W:0]   ratio_q,
  output ofs_code_e      code_q
);

  localparam int unsigned RW = N_W + 1;
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [N_W-1:0] n_shadow_q;

  function automatic logic [RW-1:0] add_ofs(input logic [N_W-1:0] n, input ofs_code_e c);
    return {1'b0, n} + {{(RW-2){1'b0}}, c} - ONE;
  endfunction

  assign ratio_next = add_ofs(n_in, ofs_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q    <= '0;
      code_q     <= OFS_Z;
      n_shadow_q <= '0;
    end else if (load) begin
      ratio_q    <= ratio_next;
      code_q     <= ofs_in;
      n_shadow_q <= n_in;
    end
  end

  // R2: the ratio in use stays within N-1..N+2 of the sampled N
  p_ratio_window_r2: assert property (@(posedge clk) disable iff (rst)
    (ratio_q == '0) || (((ratio_q + ONE) >= {1'b0, n_shadow_q}) &&
                        (ratio_q <= ({1'b0, n_shadow_q} + RW'(2)))));

  // R10: ratio and code hold between boundaries
  p_hold_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(ratio_q) && $stable(code_q)));

endmodule

// File: rtl/sdm_prog_counter.sv
module sdm_prog_counter #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio_in,
  output logic         pulse,
  output logic [W-1:0] cnt_q
);

  localparam logic [W-1:0] ONE = W'(1);

  assign pulse = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (pulse) cnt_q <= ratio_in - ONE;
    else            cnt_q <= cnt_q - ONE;
  end

  // R4: the counter steps down by one between pulses
  p_countdown_r4: assert property (@(posedge clk) disable iff (rst)
    !pulse |=> (cnt_q == $past(cnt_q) - ONE));

  // R4: a pulse lasts one clock when the ratio is at least two
  p_one_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (pulse && (ratio_in >= W'(2))) |=> !pulse);

endmodule

// File: rtl/sdm_frac_divider.sv
module sdm_frac_divider
  import sdm_pkg::*;
#(
  parameter int unsigned N_W    = 10,
  parameter int unsigned FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_W-1:0]    n_ratio,
  input  logic [FRAC_W-2:0] k_frac,
  output logic              div_pulse,
  output logic [N_W:0]      ratio_now,
  output logic [1:0]        mod_offset
);

  localparam int unsigned RW = N_W + 1;

  logic         boundary;
  ofs_code_e    ofs_next;
  ofs_code_e    code_q;
  logic         c1_evt;
  logic         c2_evt;
  logic [RW-1:0] ratio_next;
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] cnt_q;

  sdm_mash11 #(.FRAC_W(FRAC_W)) mod_i (
    .clk     (clk),
    .rst     (rst),
    .step    (boundary),
    .k_prog  (k_frac),
    .ofs_next(ofs_next),
    .c1_evt  (c1_evt),
    .c2_evt  (c2_evt)
  );

  sdm_ratio_sum #(.N_W(N_W)) sum_i (
    .clk       (clk),
    .rst       (rst),
    .load      (boundary),
    .n_in      (n_ratio),
    .ofs_in    (ofs_next),
    .ratio_next(ratio_next),
    .ratio_q   (ratio_q),
    .code_q    (code_q)
  );

  sdm_prog_counter #(.W(RW)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .ratio_in(ratio_next),
    .pulse   (boundary),
    .cnt_q   (cnt_q)
  );

  assign div_pulse  = boundary;
  assign ratio_now  = ratio_q;
  assign mod_offset = code_q;

  // R1: the first boundary after reset adds no offset
  p_first_ratio_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ofs_next == OFS_Z));

  // R4: the counter never exceeds the ratio in use
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (ratio_q == '0) || (cnt_q < ratio_q));

  // R9: a first-stage carry never yields a negative offset
  p_c1_nonneg_r9: assert property (@(posedge clk) disable iff (rst)
    c1_evt |-> (ofs_next != OFS_M1));

endmodule

// File: tb/sdm_frac_divider_tb_top.sv
`timescale 1ns/1ps
module sdm_frac_divider_tb_top;

  localparam int N_W    = 10;
  localparam int FRAC_W = 23;
  localparam longint TWO23 = 64'd1 << 23;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_W-1:0]    n_drv = 10'd3;
  logic [FRAC_W-2:0] k_drv = '0;
  logic              div_pulse;
  logic [N_W:0]      ratio_now;
  logic [1:0]        mod_offset;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  longint ma1, ma2;
  int     mcp;
  int     rec [40];

  always #5 clk = ~clk;

  sdm_frac_divider #(.N_W(N_W), .FRAC_W(FRAC_W)) dut_i (
    .clk(clk), .rst(rst), .n_ratio(n_drv), .k_frac(k_drv),
    .div_pulse(div_pulse), .ratio_now(ratio_now), .mod_offset(mod_offset)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model of the two-accumulator offset
  task automatic model_step(input int k, output int off);
    longint kf, s1, s2;
    int c1, c2;
    kf = (longint'(k) << 1) | 1;
    s1 = ma1 + kf;
    c1 = (s1 >= TWO23) ? 1 : 0;
    ma1 = s1 % TWO23;
    s2 = ma2 + ma1;
    c2 = (s2 >= TWO23) ? 1 : 0;
    ma2 = s2 % TWO23;
    off = c1 + c2 - mcp;
    mcp = c2;
  endtask

  // Called at a falling edge where div_pulse is high
  task automatic step_cycle(input int chg_at, input int nn, input int kk, output int r);
    int off, exp, k;
    bit ok_hold;
    model_step(int'(k_drv), off);
    exp = int'(n_drv) + off;
    @(negedge clk);
    chk(ratio_now == exp, "R9 ratio vs model", ratio_now, exp);
    chk(mod_offset == off + 1, "R3 offset code", mod_offset, off + 1);
    chk((exp >= int'(n_drv) - 1) && (exp <= int'(n_drv) + 2) &&
        (ratio_now >= exp - 0), "R2 ratio window", ratio_now, exp);
    k = 1;
    ok_hold = 1;
    while (!div_pulse) begin
      if (k == chg_at) begin
        n_drv = nn[N_W-1:0];
        k_drv = kk[FRAC_W-2:0];
      end
      @(negedge clk);
      k++;
      if (ratio_now != exp || mod_offset != off + 1) ok_hold = 0;
    end
    chk(ok_hold, "R10 ratio held in cycle", ratio_now, exp);
    chk(k == exp, "R4 pulse spacing", k, exp);
    r = exp;
  endtask

  task automatic do_reset(input int n, input int k);
    rst = 1'b1;
    n_drv = n[N_W-1:0];
    k_drv = k[FRAC_W-2:0];
    repeat (3) @(negedge clk);
    chk(ratio_now == 0, "R1 reset ratio", ratio_now, 0);
    chk(mod_offset == 1, "R1 reset offset code", mod_offset, 1);
    chk(div_pulse == 1'b1, "R1 reset pulse", div_pulse, 1);
    rst = 1'b0;
    ma1 = 0; ma2 = 0; mcp = 0;
  endtask

  task automatic run_seq(input int n, input int k, input int m);
    longint total, base;
    int r;
    do_reset(n, k);
    total = 0;
    for (int i = 0; i < m; i++) begin
      step_cycle(-1, 0, 0, r);
      if (i == 0) chk(r == n, "R1 first ratio is N", r, n);
      total += r;
    end
    base = longint'(m) * n + (longint'(m) * ((longint'(k) << 1) | 1)) / TWO23;
    chk(total == base || total == base + 1, "R6 average ratio", total, base);
  endtask

  task automatic test_lsb_forced();
    int r;
    bit flat;
    do_reset(5, 0);
    flat = 1;
    for (int i = 1; i <= 4097; i++) begin
      step_cycle(-1, 0, 0, r);
      if (i < 4096 && r != 5) flat = 0;
      if (i == 4096) chk(r == 6, "R5 cycle 4096 ratio", r, 6);
      if (i == 4097) chk(r == 4, "R5 cycle 4097 ratio", r, 4);
    end
    chk(flat, "R5 ratio flat before 4096", 0, 1);
  endtask

  task automatic test_midcycle();
    int r;
    do_reset(50, 22'h2AAAAA);
    step_cycle(-1, 0, 0, r);
    // change inputs ten clocks into a cycle of ratio ~50
    step_cycle(10, 9, 22'h000100, r);
    chk(r >= 49 && r <= 52, "R7 old N kept in cycle", r, 50);
    step_cycle(-1, 0, 0, r);
    chk(r >= 8 && r <= 11, "R7 new N at boundary", r, 9);
  endtask

  task automatic test_restart();
    int r;
    bit same;
    do_reset(12, 22'h13579B);
    for (int i = 0; i < 40; i++) begin
      step_cycle(-1, 0, 0, r);
      rec[i] = r;
    end
    do_reset(12, 22'h13579B);
    same = 1;
    for (int i = 0; i < 40; i++) begin
      step_cycle(-1, 0, 0, r);
      if (r != rec[i]) same = 0;
    end
    chk(same, "R8 restart repeats sequence", 0, 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    run_seq(20, 22'h155555, 400);
    run_seq(3, 22'h3FFFFF, 600);
    run_seq(1000, 22'h200000, 60);
    test_lsb_forced();
    test_midcycle();
    test_restart();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule